// File: doc/BRIEF.md
# Serial Flash Fast-Read Target

This block is the target side of a serial flash memory, limited to the high-speed read command. It oversamples the serial clock, the active-low select and the serial data input with the system clock. Each select-low transaction is parsed as an 8-bit command, a 24-bit byte address and one dummy byte. After that, bytes from an internal byte array stream out on the serial data output for as long as the serial clock keeps running.

The read address starts wherever the host asked and steps by one after every byte. At the top of the array it wraps to zero. Address bits above those needed for the array are dropped. The read is refused when the `busy` input shows that an erase, program or write cycle is running. A preload port on the system clock fills the array.

Top module: `spi_fastread_target`

## Requirements
- R1: While `cs_n` is high, and from reset, `sdo_oe` is 0.
- R2: Command, address and dummy bits are taken on rising edges of `sck`, most significant bit first. The order is an 8-bit command, 24 address bits, then 8 dummy bits. `sdo_oe` stays 0 through all 40 header bits.
- R3: The first data bit is driven on the `sck` falling edge after the 40th rising edge. Data bits change only on falling edges, each byte most significant bit first, and `sdo_oe` is 1 during the data phase.
- R4: The first byte comes from the received address, and each following byte comes from the next higher address.
- R5: After the byte at index DEPTH-1, the stream continues at index 0 without limit.
- R6: Only the low log2(DEPTH) address bits select a byte. All higher address bits are ignored.
- R7: Raising `cs_n` ends the transaction at any point, including inside a data byte. The next transaction is not affected.
- R8: Only command 8'h0B starts a read. Any other command keeps `sdo_oe` at 0 until `cs_n` goes high.
- R9: If `busy` is 1 when the last command bit is taken, the read is rejected and `sdo_oe` stays 0 for that transaction.
- R10: A `pre_we` pulse writes `pre_data` into the array at `pre_addr`, and later reads return that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low select |
| sdi | input | 1 | Serial data from the host |
| busy | input | 1 | High while an internal erase, program or write cycle runs |
| pre_we | input | 1 | Preload write strobe |
| pre_addr | input | $clog2(DEPTH) | Preload byte index |
| pre_data | input | 8 | Preload byte |
| sdo | output | 1 | Serial data to the host |
| sdo_oe | output | 1 | Output enable for `sdo`; the pin is high-impedance when this is 0 |

## Verification
Two functions can fall in the same cycle: the address step and its wrap to zero, and the load of the next byte. Both happen on the falling edge that drives the last bit of a byte. Reads are started at a high index, with extra address bits set above the array, so that this edge lands on the index DEPTH-1. A scoreboard queue then has to see the byte at DEPTH-1 followed directly by the byte at index 0. A second case stops a stream in the middle of a byte. Here the bench checks that the output enable drops and that a fresh read from another address returns clean data.

// File: rtl/spi_fastread_target.sv
module spi_fastread_target #(
  parameter int DEPTH  = 256,
  parameter logic [7:0] OPCODE = 8'h0B,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sck,
  input  logic          cs_n,
  input  logic          sdi,
  input  logic          busy,
  input  logic          pre_we,
  input  logic [AW-1:0] pre_addr,
  input  logic [7:0]    pre_data,
  output logic          sdo,
  output logic          sdo_oe
);

  typedef enum logic [1:0] {ST_HDR, ST_DATA, ST_SKIP} st_t;

  logic [7:0]    mem [DEPTH];
  logic          s_sck, s_cs, s_sdi, sck_d;
  st_t           st;
  logic [5:0]    hcnt;
  logic [30:0]   sh;
  logic [AW-1:0] addr;
  logic [7:0]    dbyte;
  logic [2:0]    bidx;
  logic          sdo_r, oe_r;

  wire rise = s_sck & ~sck_d;
  wire fall = ~s_sck & sck_d;
  wire [31:0] hdr_word = {sh, s_sdi};
  wire [AW-1:0] nxt = (addr == AW'(DEPTH-1)) ? '0 : addr + 1'b1;

  assign sdo    = sdo_r;
  assign sdo_oe = oe_r;

  always_ff @(posedge clk) begin
    if (pre_we) mem[pre_addr] <= pre_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_sck <= 1'b0;
      s_cs  <= 1'b1;
      s_sdi <= 1'b0;
      sck_d <= 1'b0;
      st    <= ST_HDR;
      hcnt  <= '0;
      sh    <= '0;
      addr  <= '0;
      dbyte <= '0;
      bidx  <= 3'd7;
      sdo_r <= 1'b0;
      oe_r  <= 1'b0;
    end else begin
      s_sck <= sck;
      s_cs  <= cs_n;
      s_sdi <= sdi;
      sck_d <= s_sck;
      if (s_cs) begin
        st   <= ST_HDR;
        hcnt <= '0;
        bidx <= 3'd7;
        oe_r <= 1'b0;
      end else begin
        case (st)
          ST_HDR: if (rise) begin
            sh   <= hdr_word[30:0];
            hcnt <= hcnt + 6'd1;
            if (hcnt == 6'd7 && (hdr_word[7:0] != OPCODE || busy))
              st <= ST_SKIP;
            if (hcnt == 6'd31)
              addr <= hdr_word[AW-1:0];
            if (hcnt == 6'd39) begin
              st    <= ST_DATA;
              dbyte <= mem[addr];
              bidx  <= 3'd7;
            end
          end
          ST_DATA: if (fall) begin
            sdo_r <= dbyte[bidx];
            oe_r  <= 1'b1;
            if (bidx == 3'd0) begin
              addr  <= nxt;
              dbyte <= mem[nxt];
              bidx  <= 3'd7;
            end else begin
              bidx <= bidx - 3'd1;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/spi_fastread_target_chk.sv
module spi_fastread_target_chk #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          sdo,
  input logic          sdo_oe,
  input logic          fall,
  input logic [5:0]    hcnt,
  input logic [1:0]    st,
  input logic [AW-1:0] addr
);

  AST_QUIET_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n && $past(cs_n) && $past(cs_n, 2) |-> !sdo_oe); // R1

  AST_EDGE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    sdo != $past(sdo) |-> $past(fall)); // R3

  AST_HEADER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> hcnt == 6'd40); // R2

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    st == 2'd1 && $past(st) == 2'd1 && addr != $past(addr)
      |-> addr == (($past(addr) == AW'(DEPTH-1)) ? '0 : $past(addr) + 1'b1)); // R5

  AST_REJECT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    st == 2'd2 |-> !sdo_oe); // R8

endmodule

bind spi_fastread_target spi_fastread_target_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sdo(sdo), .sdo_oe(sdo_oe),
  .fall(fall), .hcnt(hcnt), .st(st), .addr(addr)
);

// File: tb/spi_fastread_target_tb_top.sv
module spi_fastread_target_tb_top;
  localparam int DEPTH = 256;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, sdi = 1'b0, busy = 1'b0;
  logic pre_we = 1'b0;
  logic [AW-1:0] pre_addr = '0;
  logic [7:0] pre_data = '0;
  logic sdo, sdo_oe;

  logic [7:0] model [DEPTH];
  logic [7:0] exp_q [$];
  logic [7:0] got_byte;
  event got_ev;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  spi_fastread_target #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .sdi(sdi), .busy(busy),
    .pre_we(pre_we), .pre_addr(pre_addr), .pre_data(pre_data),
    .sdo(sdo), .sdo_oe(sdo_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(got_ev) begin
    logic [7:0] e;
    if (exp_q.size() == 0) begin
      chk(1'b0, "R4 unexpected byte", got_byte, 0);
    end else begin
      e = exp_q.pop_front();
      chk(got_byte == e, "R4/R5/R6 stream byte", got_byte, e);
    end
  end

  task automatic bit_cyc(input logic b, output logic q, output logic oe);
    sdi = b;
    repeat (2) @(negedge clk);
    sck = 1'b1;
    repeat (4) @(negedge clk);
    sck = 1'b0;
    repeat (4) @(negedge clk);
    q = sdo;
    oe = sdo_oe;
  endtask

  task automatic sel();
    cs_n = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic desel(input string req);
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(sdo_oe == 1'b0, req, sdo_oe, 0);
  endtask

  task automatic preload(input int idx, input logic [7:0] v);
    pre_we = 1'b1; pre_addr = AW'(idx); pre_data = v;
    @(negedge clk);
    pre_we = 1'b0;
    model[idx] = v;
  endtask

  // full bytes read after header; extra = trailing bits of a partial byte
  task automatic read_stream(input logic [7:0] op, input logic [23:0] a,
                             input int nbytes, input int extra, input bit expect_ok);
    logic [39:0] hdr;
    logic q, oe;
    logic [7:0] acc;
    int nb;
    hdr = {op, a, 8'hA5};
    if (expect_ok)
      for (int k = 0; k < nbytes; k++)
        exp_q.push_back(model[(int'(a[AW-1:0]) + k) % DEPTH]);
    sel();
    for (int i = 39; i >= 1; i--) begin
      bit_cyc(hdr[i], q, oe);
      if (i > 1 || !expect_ok) chk(oe == 1'b0, "R2 quiet header", oe, 0);
    end
    acc = '0; nb = 0;
    bit_cyc(hdr[0], q, oe);
    for (int j = 0; j < nbytes * 8 + extra; j++) begin
      if (j > 0) bit_cyc(1'b0, q, oe);
      if (expect_ok) begin
        chk(oe == 1'b1, "R3 data enable", oe, 1);
        acc = {acc[6:0], q};
        nb++;
        if (nb == 8) begin
          got_byte = acc;
          -> got_ev;
          nb = 0;
          #1;
        end
      end else begin
        chk(oe == 1'b0, op != 8'h0B ? "R8 wrong command silent" : "R9 busy reject", oe, 0);
      end
    end
    desel("R7 deselect ends");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(sdo_oe == 1'b0, "R1 reset state", sdo_oe, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sdo_oe == 1'b0, "R1 idle after reset", sdo_oe, 0);
    for (int i = 0; i < DEPTH; i++) preload(i, 8'((i * 37 + 11) ^ (i >> 3)));

    read_stream(8'h0B, 24'h000000, 3, 0, 1);      // R4 from zero
    read_stream(8'h0B, 24'h00005A, 4, 0, 1);      // R4 arbitrary start
    read_stream(8'h0B, 24'h0000FD, 5, 0, 1);      // R5 wrap
    read_stream(8'h0B, 24'hF3A0FE, 4, 0, 1);      // R6 upper bits ignored, wrap
    read_stream(8'h0B, 24'h000010, 1, 4, 1);      // R7 abort mid-byte
    read_stream(8'h0B, 24'h000080, 2, 0, 1);      // R7 next transaction clean
    read_stream(8'h03, 24'h000010, 2, 0, 0);      // R8 other command
    read_stream(8'h1B, 24'h000010, 1, 0, 0);      // R8 other command
    busy = 1'b1;
    read_stream(8'h0B, 24'h000020, 2, 0, 0);      // R9 busy reject
    busy = 1'b0;
    read_stream(8'h0B, 24'h000020, 2, 0, 1);      // R9 accepted once idle
    preload(8'h33, 8'hC6);                        // R10 overwrite
    preload(8'h34, 8'h19);
    read_stream(8'h0B, 24'h000033, 2, 0, 1);      // R10 read back
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R4 all bytes seen", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule